// File: doc/BRIEF.md
# Programmable Clock Synthesizer Divider Control

This block holds the digital control for a frequency synthesizer and runs on the VCO clock. A 16-bit control word carries three settings. A one-bit prescaler select (W) and a six-bit loop modulus (Y) set the feedback divider, which sends a one-cycle pulse to the phase comparator. A one-bit post-divider select (X) sets the rate of a system clock enable pulse. When the loop is locked, the VCO settles at 16·fref·(Y+1)·4^W. The system clock is one quarter of the VCO clock when X=0 and one half when X=1.

W and Y sit inside the loop. A write that changes either of them clears the lock flag. The flag sets again after a fixed number of feedback pulses, the number being a parameter that stands in for real lock detection. X sits outside the loop, so changing it never disturbs the lock flag. The new W, Y and X values are applied only at the boundary of the divider each one affects, so no pulse comes out short.

Top module: `clk_synth_ctl`

## Requirements
- R1: After reset the control word reads 16'h3F00 (W=0, X=0, Y=63, lock flag 0) and `locked` is low.
- R2: `fb_pulse` is high for one VCO cycle every 16·(Y+1)·4^W VCO cycles.
- R3: `sys_en` is high for one VCO cycle every 4 cycles when X=0 and every 2 cycles when X=1.
- R4: A write that changes W or Y drives `locked` low in the cycle after the write.
- R5: After a relock starts, or after reset, `locked` goes high in the cycle after the LOCK_PULSES-th feedback pulse (default 4). The pulse that ends the feedback period in progress counts as the first of these pulses.
- R6: A write that changes only X, or that rewrites the same W and Y, leaves `locked` high and leaves the feedback period unchanged.
- R7: New W and Y values take effect at the next feedback pulse. The period in progress finishes with the old ratio.
- R8: A change of X takes effect at the next `sys_en` pulse. No gap between `sys_en` pulses differs from 2 or 4 cycles.
- R9: Read layout: W at bit 15, X at bit 14, Y at bits 13:8, lock flag at bit 3. All other bits read 0. Writes to bits 7:0 have no effect, and that includes the lock flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Control word readback with the lock flag |
| fb_pulse | output | 1 | Feedback pulse to the phase comparator |
| sys_en | output | 1 | System clock enable |
| locked | output | 1 | Lock status |

## Verification
The assertions check the following on every cycle. Feedback and enable pulses last one cycle. A W or Y change clears the lock flag in the next cycle. The flag only rises just after a feedback pulse. A write that changes only X never drops a held lock. The bench scenarios are the only place where several other properties can be seen, because each involves counting over many cycles: the exact feedback and enable periods, the old period finishing before a new ratio takes effect, the gaps around an X change, and the number of pulses before lock returns.

// File: rtl/synth_pkg.sv
// Shared types and constants for the clock synthesizer divider control.
// Assumes a 16-bit control word with W at bit 15, X at bit 14, Y at 13:8.
package synth_pkg;
    localparam int Y_W    = 6;
    localparam int CTRL_W = 16;

    typedef struct packed {
        logic           w;   // prescaler tap select (inside the loop)
        logic           x;   // post-divider select (outside the loop)
        logic [Y_W-1:0] y;   // loop modulus minus one
    } synth_cfg_t;

    localparam synth_cfg_t CFG_RESET = '{w: 1'b0, x: 1'b0, y: {Y_W{1'b1}}};
endpackage

// File: rtl/fb_divider.sv
// Feedback divider: a prescaler whose length is PRE_BASE or 4*PRE_BASE,
// picked by W, feeding a modulo-2^YW down-counter that is loaded with Y.
// Emits a one-cycle pulse every PRE_BASE*4^W*(Y+1) cycles. W and Y are only
// sampled on the reload at the pulse, so no period is ever truncated.
// Assumes PRE_BASE >= 2.
module fb_divider #(
    parameter int PRE_BASE = 16,
    parameter int YW       = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_w,
    input  logic [YW-1:0] cfg_y,
    output logic          fb_pulse
);
    localparam int PW = $clog2(PRE_BASE * 4);
    localparam logic [PW-1:0] TAP_LO = PW'(PRE_BASE - 1);
    localparam logic [PW-1:0] TAP_HI = PW'(PRE_BASE * 4 - 1);

    logic [PW-1:0] pre_cnt;
    logic [YW-1:0] mod_cnt;
    logic          act_w;
    logic          pre_end;

    // Terminal count of the prescaler for the tap currently in use.
    always_comb pre_end = (pre_cnt == (act_w ? TAP_HI : TAP_LO));

    // The pulse fires when the prescaler and the modulus counter both end.
    always_comb fb_pulse = pre_end && (mod_cnt == '0);

    // Step the prescaler, and step or reload the modulus counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            mod_cnt <= '1;
            act_w   <= 1'b0;
        end else if (pre_end) begin
            pre_cnt <= '0;
            if (mod_cnt == '0) begin
                mod_cnt <= cfg_y;
                act_w   <= cfg_w;
            end else begin
                mod_cnt <= mod_cnt - 1'b1;
            end
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    assert_fb_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse)
        else $error("feedback pulse longer than one cycle");
endmodule

// File: rtl/sys_div.sv
// System clock enable divider: one-cycle pulse every DIV_SLOW cycles
// (X=0) or every DIV_FAST cycles (X=1). X is sampled only at a pulse,
// so each gap equals the old or the new ratio.
// Assumes DIV_SLOW > DIV_FAST >= 2.
module sys_div #(
    parameter int DIV_SLOW = 4,
    parameter int DIV_FAST = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_x,
    output logic sys_en
);
    localparam int CW = $clog2(DIV_SLOW);
    localparam logic [CW-1:0] END_SLOW = CW'(DIV_SLOW - 1);
    localparam logic [CW-1:0] END_FAST = CW'(DIV_FAST - 1);

    logic [CW-1:0] div_cnt;
    logic          act_x;

    // The enable fires at the end of the ratio currently in use.
    always_comb sys_en = (div_cnt == (act_x ? END_FAST : END_SLOW));

    // Count the phase, and take a new ratio only at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            act_x   <= 1'b0;
        end else if (sys_en) begin
            div_cnt <= '0;
            act_x   <= cfg_x;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assert_sys_en_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sys_en |=> !sys_en)
        else $error("system enable asserted on consecutive cycles");
endmodule

// File: rtl/lock_timer.sv
// Lock model: clears the flag on a relock request and sets it again after
// LOCK_PULSES feedback pulses. Reset acts as a relock request.
// Assumes LOCK_PULSES >= 1. A relock request wins over a pulse in the same cycle.
module lock_timer #(
    parameter int LOCK_PULSES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic relock,
    input  logic fb_pulse,
    output logic locked
);
    localparam int CW = $clog2(LOCK_PULSES + 1);
    localparam logic [CW-1:0] LAST = CW'(LOCK_PULSES - 1);

    logic [CW-1:0] pulse_cnt;

    // Count feedback pulses while unlocked, and restart on a relock request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_cnt <= '0;
            locked    <= 1'b0;
        end else if (relock) begin
            pulse_cnt <= '0;
            locked    <= 1'b0;
        end else if (!locked && fb_pulse) begin
            if (pulse_cnt == LAST) locked <= 1'b1;
            else                   pulse_cnt <= pulse_cnt + 1'b1;
        end
    end

    assert_relock_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        relock |=> !locked)
        else $error("lock flag not cleared by relock");

    assert_lock_after_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(fb_pulse))
        else $error("lock flag rose without a feedback pulse");
endmodule

// File: rtl/clk_synth_ctl.sv
// Top of the clock synthesizer divider control. Holds the control word,
// detects writes that touch the loop (W or Y) and drives the feedback
// divider, the system enable divider and the lock model. Clocked by the VCO.
// Assumes that software writes only W/X/Y combinations within the
// frequency limits. Bits 7:0 of a write are ignored.
module clk_synth_ctl #(
    parameter int PRE_BASE    = 16,
    parameter int LOCK_PULSES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        fb_pulse,
    output logic        sys_en,
    output logic        locked
);
    import synth_pkg::*;

    synth_cfg_t cfg;
    synth_cfg_t wr_cfg;
    logic       relock;
    logic [7:0] wr_unused_bits;

    // Split the write word into its fields. The low byte is discarded.
    always_comb begin
        wr_cfg.w       = wr_data[15];
        wr_cfg.x       = wr_data[14];
        wr_cfg.y       = wr_data[13:8];
        wr_unused_bits = wr_data[7:0];
    end

    // A write starts a relock only if it changes a loop setting.
    always_comb relock = wr_en && ((wr_cfg.w != cfg.w) || (wr_cfg.y != cfg.y));

    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg <= CFG_RESET;
        else if (wr_en) cfg <= wr_cfg;
    end

    // Readback with the lock flag at bit 3 and zeros elsewhere.
    always_comb rd_data = {cfg.w, cfg.x, cfg.y, 4'b0000, locked, 3'b000};

    fb_divider #(.PRE_BASE(PRE_BASE), .YW(Y_W)) u_fb (
        .clk(clk), .rst_n(rst_n), .cfg_w(cfg.w), .cfg_y(cfg.y), .fb_pulse(fb_pulse)
    );

    sys_div #(.DIV_SLOW(4), .DIV_FAST(2)) u_sys (
        .clk(clk), .rst_n(rst_n), .cfg_x(cfg.x), .sys_en(sys_en)
    );

    lock_timer #(.LOCK_PULSES(LOCK_PULSES)) u_lock (
        .clk(clk), .rst_n(rst_n), .relock(relock), .fb_pulse(fb_pulse), .locked(locked)
    );

    assert_x_only_keeps_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !relock && locked) |=> locked)
        else $error("write outside the loop dropped the lock");
endmodule

// File: tb/sim_clk_synth_ctl.sv
module sim_clk_synth_ctl;
    localparam int LOCKN = 4;
    localparam int WATCHDOG = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0000;
    logic [15:0] rd_data;
    logic        fb_pulse, sys_en, locked;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int cur_w = 0, cur_x = 0, cur_y = 63;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    clk_synth_ctl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .fb_pulse(fb_pulse), .sys_en(sys_en), .locked(locked)
    );

    function automatic int fb_period(int w, int y);
        return 16 * (y + 1) * ((w != 0) ? 4 : 1);
    endfunction

    function automatic int word(int w, int x, int y, int l);
        return (w << 15) | (x << 14) | (y << 8) | (l << 3);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_fb(output int t);
        do @(negedge clk); while (fb_pulse !== 1'b1);
        t = cyc;
    endtask

    task automatic wait_sys(output int t);
        do @(negedge clk); while (sys_en !== 1'b1);
        t = cyc;
    endtask

    task automatic write_word(input int d);
        @(posedge clk); #1;
        wr_en = 1'b1;
        wr_data = 16'(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Change the setting, then check the old period finishing, the new period,
    // the relock sequence and the enable rate.
    task automatic reconfig(input int w, input int x, input int y);
        int t0, t1, t2, tn, s0, s1;
        int old_p, new_p;
        bit loop_chg;
        old_p = fb_period(cur_w, cur_y);
        new_p = fb_period(w, y);
        loop_chg = (w != cur_w) || (y != cur_y);
        wait_fb(t0);
        repeat (3) @(posedge clk);
        write_word(word(w, x, y, 0));
        @(negedge clk);
        if (loop_chg) chk("R4 lock cleared after loop write", int'(locked), 0);
        else          chk("R6 lock kept on X-only write", int'(locked), 1);
        wait_fb(t1);
        chk("R7 period in progress keeps old ratio", t1 - t0, old_p);
        wait_fb(t2);
        chk("R2 feedback period", t2 - t1, new_p);
        if (loop_chg) begin
            for (int k = 2; k < LOCKN; k++) wait_fb(tn);
            chk("R5 still unlocked at last pulse", int'(locked), 0);
            @(negedge clk);
            chk("R5 locked after pulses", int'(locked), 1);
        end else begin
            chk("R6 lock held", int'(locked), 1);
        end
        chk("R9 readback", int'(rd_data), word(w, x, y, 1));
        wait_sys(s0);
        wait_sys(s1);
        chk("R3 enable period", s1 - s0, (x != 0) ? 2 : 4);
        cur_w = w; cur_x = x; cur_y = y;
    endtask

    always @(posedge clk) begin
        if (cyc == WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual cycle %0d expected finish earlier", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t, tp, s0, s1, sa, sb;
        int seed;
        seed = $urandom(32'd4242);
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset readback", int'(rd_data), 16'h3F00);
        chk("R1 reset lock low", int'(locked), 0);
        // R3 slow enable rate
        wait_sys(s0); wait_sys(s1);
        chk("R3 enable period X=0", s1 - s0, 4);
        wait_sys(s0);
        chk("R3 enable period X=0 again", s0 - s1, 4);
        // R2 / R5 reset lock acquisition
        wait_fb(tp);
        for (int k = 1; k < LOCKN; k++) begin
            wait_fb(t);
            chk("R2 reset period", t - tp, 1024);
            tp = t;
            if (k < LOCKN - 1) chk("R5 not yet locked", int'(locked), 0);
        end
        chk("R5 unlocked at final pulse", int'(locked), 0);
        @(negedge clk);
        chk("R5 locked after reset pulses", int'(locked), 1);
        // R9 reserved bits and lock bit not writable, same W/Y keeps lock
        write_word(16'h3FFF);
        @(negedge clk);
        chk("R9 reserved bits ignored", int'(rd_data), 16'h3F08);
        chk("R6 same loop setting keeps lock", int'(locked), 1);
        write_word(16'h3F00);
        // R8 X change: gaps only 2 or 4, ending at 2
        wait_sys(sa);
        write_word(16'h7F00);
        @(negedge clk);
        chk("R6 lock kept after X change", int'(locked), 1);
        for (int k = 0; k < 6; k++) begin
            wait_sys(sb);
            if ((sb - sa) != 2 && (sb - sa) != 4)
                chk("R8 enable gap legal", sb - sa, 2);
            else
                chk("R8 enable gap legal", 1, 1);
            sa = sb;
        end
        wait_sys(sb);
        chk("R8 enable gap after X change", sb - sa, 2);
        cur_x = 1;
        wait_fb(tp); wait_fb(t);
        chk("R6 feedback period unchanged by X", t - tp, 1024);
        // Directed loop changes
        reconfig(0, 1, 3);
        reconfig(1, 0, 0);
        reconfig(1, 0, 63);
        reconfig(0, 0, 0);
        reconfig(0, 1, 0);
        // Constrained random settings
        for (int i = 0; i < 8; i++) begin
            int rw, rx, ry;
            rw = int'($urandom() % 2);
            rx = int'($urandom() % 2);
            ry = int'($urandom() % 16);
            reconfig(rw, rx, ry);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule